// File: doc/BRIEF.md
# Framed Serial Configuration Port with Frame-Sync Commit

This block is the configuration port of a dual-bank line memory. A host controller talks to it over a four-wire serial link: an active-low select, a serial clock, data in and data out. Each access sits inside one select-low window. It opens with a command byte that picks either the configuration group or the status group, and whether the access reads or writes. Bits travel most-significant first. The port samples data in on the rising serial clock, and presents data out before each rising edge.

A write carries five payload bytes and ends with a stop byte. The payload holds the read start address with its count direction, the write start address, and the horizontal pre-count. The stop byte holds a fixed code and an even-parity bit. Only a frame whose stop byte checks out reaches the shadow copy. The shadow copy moves into the live registers on the next rising edge of the vertical sync input, so the memory never sees a half-updated setting in the middle of a field. A read returns a snapshot of the running address and horizontal counters. A status read returns an error flag and a load-pending flag.

All serial pins and the sync input are oversampled by the system clock. The data-out pin is shown as a value plus an enable, and the enable drives the pad's output buffer.

Top module: `framed_reg_port`

## Requirements
- R1: After synchronous reset the live read start, direction, write start and pre-count outputs are zero, both status flags are zero and `spi_sdo_en` is low.
- R2: Command byte fields: bits 7:4 are the group, bit 3 is read-enable, bit 2 is write-enable, and bits 1:0 must be zero. Group 0000 with only write-enable set (0x04) is a write, and with only read-enable set (0x08) is a read. Group 1111 with only read-enable set (0xF8) is a status read. Every other command byte is ignored until select rises again: no flag or register changes and the output stays disabled.
- R3: A write frame has 7 bytes. Byte 1 is {5'b0, dir, rd_start[9:8]}. Byte 2 is rd_start[7:0]. Byte 3 is {6'b0, wr_start[9:8]}. Byte 4 is wr_start[7:0]. Byte 5 is the pre-count. Byte 6 is the stop byte. The padding bits are ignored.
- R4: A stop byte whose upper seven bits are not 1110010, or whose parity bit (bit 0) leaves an odd number of ones across payload bytes 1 to 5 and the stop byte, sets the error flag. It leaves the shadow copy and the pending flag unchanged.
- R5: A write frame with a correct stop byte loads the shadow copy, sets the pending flag and clears the error flag. The live outputs stay unchanged.
- R6: On a rising edge of `vsync` with the pending flag set, the shadow copy moves into the live outputs and the pending flag clears. With the flag clear, the edge changes nothing.
- R7: When two valid writes arrive before one sync edge, the live outputs take the values of the later one.
- R8: After command 0x08, the next 40 bits on `spi_sdo` are {6'b0, rd_cnt_i}, {6'b0, wr_cnt_i}, hd_cnt_i, MSB first. The counters are sampled when the command byte completes. The direction bit is not included.
- R9: After command 0xF8, the next byte on `spi_sdo` is {error, pending, 6'b000000}.
- R10: `spi_sdo_en` is high only while return bits are being shifted out. It is low during the command byte, after the last return bit, and while select is high.
- R11: A frame cut short by select rising before its stop byte changes no flag, no shadow value and no live output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples all serial pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Serial select, active low |
| spi_sck | input | 1 | Serial clock from host |
| spi_sdi | input | 1 | Serial data from host |
| spi_sdo | output | 1 | Serial data to host |
| spi_sdo_en | output | 1 | Output buffer enable for `spi_sdo` |
| vsync | input | 1 | Vertical sync; rising edge commits the shadow copy |
| rd_cnt_i | input | 10 | Running read address counter |
| wr_cnt_i | input | 10 | Running write address counter |
| hd_cnt_i | input | 8 | Running horizontal pre-counter |
| rd_start_o | output | 10 | Live read start address |
| rd_dir_o | output | 1 | Live read count direction (1 = down) |
| wr_start_o | output | 10 | Live write start address |
| hd_precount_o | output | 8 | Live horizontal pre-count |

## Verification
The bench builds the top with its default two-stage synchronizer and runs the serial clock at eight system clocks per half period. This keeps the synchronizer delay, the command decode and the reply load well inside one bit time, so each bit-level handoff between the receiver and the shifter can be seen at the pins. The 10-bit address width fills both high bytes with padding, direction and address bits, so a misplaced field shows up in the committed values. The pattern table runs a commit, a pending write, a bad stop code, a bad parity bit and an overwrite, in sequence.

// File: rtl/frp_pkg.sv
package frp_pkg;

    localparam int BYTE_W      = 8;
    localparam int ADDR_W      = 10;
    localparam int HI_W        = ADDR_W - BYTE_W;
    localparam int PRE_W       = BYTE_W;
    localparam int DATA_BYTES  = 5;
    localparam int DATA_W      = DATA_BYTES * BYTE_W;
    localparam int FRAME_BYTES = DATA_BYTES + 2;
    localparam int BCNT_W      = $clog2(FRAME_BYTES + 1);
    localparam int BIT_W       = $clog2(BYTE_W);
    localparam int LEFT_W      = $clog2(DATA_W + 1);
    localparam int DIR_BIT     = HI_W;

    localparam logic [BYTE_W-2:0] STOP_CODE = 7'b1110010;
    localparam logic [3:0]        GRP_CFG   = 4'h0;
    localparam logic [3:0]        GRP_STAT  = 4'hF;

    typedef enum logic [1:0] {OP_NONE, OP_WRITE, OP_READ, OP_STATUS} op_e;
    typedef enum logic [1:0] {FM_CMD, FM_WRITE, FM_DRAIN} fmode_e;

    typedef struct packed {
        logic              dir;
        logic [ADDR_W-1:0] rd_start;
        logic [ADDR_W-1:0] wr_start;
        logic [PRE_W-1:0]  precount;
    } cfg_t;

    typedef struct packed {
        logic [ADDR_W-1:0] rd;
        logic [ADDR_W-1:0] wr;
        logic [PRE_W-1:0]  hd;
    } counts_t;

    function automatic op_e decode_cmd(input logic [BYTE_W-1:0] b);
        logic re;
        logic we;
        re = b[3];
        we = b[2];
        if (b[1:0] != 2'b00) return OP_NONE;
        if (b[7:4] == GRP_CFG) begin
            if (re && !we) return OP_READ;
            if (we && !re) return OP_WRITE;
            return OP_NONE;
        end
        if (b[7:4] == GRP_STAT && re && !we) return OP_STATUS;
        return OP_NONE;
    endfunction

    function automatic logic [DATA_W-1:0] pack_counts(input counts_t c);
        return {{(BYTE_W-HI_W){1'b0}}, c.rd, {(BYTE_W-HI_W){1'b0}}, c.wr, c.hd};
    endfunction

    function automatic logic stop_ok(input logic [BYTE_W-1:0] stop, input logic par_acc);
        return (stop[BYTE_W-1:1] == STOP_CODE) && ((par_acc ^ (^stop)) == 1'b0);
    endfunction

endpackage

// File: rtl/frp_sync.sv
module frp_sync #(
    parameter int                 WIDTH   = 4,
    parameter int                 STAGES  = 2,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] lvl_o,
    output logic [WIDTH-1:0] rise_o
);

    logic [WIDTH-1:0] pipe [STAGES+1];

    for (genvar s = 0; s <= STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) pipe[s] <= RST_VAL;
                else     pipe[s] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) pipe[s] <= RST_VAL;
                else     pipe[s] <= pipe[s-1];
            end
        end
    end

    assign lvl_o = pipe[STAGES-1];

    for (genvar b = 0; b < WIDTH; b++) begin : g_edge
        assign rise_o[b] = pipe[STAGES-1][b] & ~pipe[STAGES][b];
    end

endmodule

// File: rtl/frp_rx.sv
module frp_rx
    import frp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cs_n_i,
    input  logic sck_rise_i,
    input  logic sdi_i,
    output logic wr_good_o,
    output logic wr_bad_o,
    output cfg_t wr_data_o,
    output logic rd_req_o,
    output logic st_req_o
);

    logic [BYTE_W-2:0] shreg;
    logic [BIT_W-1:0]  bit_cnt;
    logic [BCNT_W-1:0] byte_cnt;
    logic              par_acc;
    fmode_e            mode;
    cfg_t              stage;
    logic [BYTE_W-1:0] byte_now;
    logic              byte_done;

    assign byte_now  = {shreg, sdi_i};
    assign byte_done = sck_rise_i && (bit_cnt == BIT_W'(BYTE_W - 1));
    assign wr_data_o = stage;

    always_ff @(posedge clk) begin
        wr_good_o <= 1'b0;
        wr_bad_o  <= 1'b0;
        rd_req_o  <= 1'b0;
        st_req_o  <= 1'b0;
        if (rst) begin
            shreg    <= '0;
            bit_cnt  <= '0;
            byte_cnt <= '0;
            par_acc  <= 1'b0;
            mode     <= FM_CMD;
            stage    <= '0;
        end else if (cs_n_i) begin
            bit_cnt  <= '0;
            byte_cnt <= '0;
            par_acc  <= 1'b0;
            mode     <= FM_CMD;
        end else if (sck_rise_i) begin
            shreg   <= byte_now[BYTE_W-2:0];
            bit_cnt <= bit_cnt + 1'b1;
            if (byte_done) begin
                if (byte_cnt != BCNT_W'(FRAME_BYTES)) byte_cnt <= byte_cnt + 1'b1;
                case (mode)
                    FM_CMD: begin
                        case (decode_cmd(byte_now))
                            OP_WRITE:  mode <= FM_WRITE;
                            OP_READ:   begin rd_req_o <= 1'b1; mode <= FM_DRAIN; end
                            OP_STATUS: begin st_req_o <= 1'b1; mode <= FM_DRAIN; end
                            default:   mode <= FM_DRAIN;
                        endcase
                    end
                    FM_WRITE: begin
                        par_acc <= par_acc ^ (^byte_now);
                        case (byte_cnt)
                            BCNT_W'(1): begin
                                stage.dir                     <= byte_now[DIR_BIT];
                                stage.rd_start[ADDR_W-1:BYTE_W] <= byte_now[HI_W-1:0];
                            end
                            BCNT_W'(2): stage.rd_start[BYTE_W-1:0] <= byte_now;
                            BCNT_W'(3): stage.wr_start[ADDR_W-1:BYTE_W] <= byte_now[HI_W-1:0];
                            BCNT_W'(4): stage.wr_start[BYTE_W-1:0] <= byte_now;
                            BCNT_W'(5): stage.precount <= byte_now;
                            BCNT_W'(6): begin
                                if (stop_ok(byte_now, par_acc)) wr_good_o <= 1'b1;
                                else                            wr_bad_o  <= 1'b1;
                                mode <= FM_DRAIN;
                            end
                            default: ;
                        endcase
                    end
                    default: ;
                endcase
            end
        end
    end

    // R2: at most one frame event per cycle
    p_single_event_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_good_o, wr_bad_o, rd_req_o, st_req_o}));

    // R11: events only arise from a serial clock edge inside a selected frame
    p_event_needs_edge_r11: assert property (@(posedge clk) disable iff (rst)
        (wr_good_o || wr_bad_o || rd_req_o || st_req_o) |-> $past(sck_rise_i && !cs_n_i));

endmodule

// File: rtl/frp_tx.sv
module frp_tx
    import frp_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    cs_n_i,
    input  logic    sck_rise_i,
    input  logic    rd_req_i,
    input  logic    st_req_i,
    input  counts_t counts_i,
    input  logic    pe_i,
    input  logic    wf_i,
    output logic    sdo_o,
    output logic    sdo_en_o
);

    logic [DATA_W-1:0] tx_sh;
    logic [LEFT_W-1:0] left;

    always_ff @(posedge clk) begin
        if (rst || cs_n_i) begin
            tx_sh <= '0;
            left  <= '0;
        end else if (rd_req_i) begin
            tx_sh <= pack_counts(counts_i);
            left  <= LEFT_W'(DATA_W);
        end else if (st_req_i) begin
            tx_sh <= {pe_i, wf_i, {(DATA_W-2){1'b0}}};
            left  <= LEFT_W'(BYTE_W);
        end else if (sck_rise_i && left != '0) begin
            tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
            left  <= left - 1'b1;
        end
    end

    assign sdo_en_o = (left != '0);
    assign sdo_o    = sdo_en_o & tx_sh[DATA_W-1];

    // R10: deselect turns the output off
    p_off_when_deselected_r10: assert property (@(posedge clk) disable iff (rst)
        cs_n_i |=> !sdo_en_o);

    // R8: output enable only starts after a read or status request
    p_en_needs_request_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(sdo_en_o) |-> $past(rd_req_i || st_req_i));

endmodule

// File: rtl/frp_commit.sv
module frp_commit
    import frp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_good_i,
    input  logic wr_bad_i,
    input  cfg_t wr_data_i,
    input  logic vs_rise_i,
    output cfg_t live_o,
    output logic pe_o,
    output logic wf_o
);

    cfg_t shadow;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= '0;
            live_o <= '0;
            pe_o   <= 1'b0;
            wf_o   <= 1'b0;
        end else begin
            if (vs_rise_i && wf_o) live_o <= shadow;
            if (wr_good_i) begin
                shadow <= wr_data_i;
                wf_o   <= 1'b1;
                pe_o   <= 1'b0;
            end else begin
                if (wr_bad_i)  pe_o <= 1'b1;
                if (vs_rise_i) wf_o <= 1'b0;
            end
        end
    end

    // R5: accepted frame marks a pending load
    p_good_sets_pending_r5: assert property (@(posedge clk) disable iff (rst)
        wr_good_i |=> (wf_o && !pe_o));

    // R4: rejected frame raises the error flag and keeps the shadow copy
    p_bad_sets_error_r4: assert property (@(posedge clk) disable iff (rst)
        wr_bad_i |=> (pe_o && $stable(shadow)));

    // R6: live values move only on a sync edge
    p_live_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !vs_rise_i |=> $stable(live_o));

    // R6: sync edge without a new frame clears the pending flag
    p_sync_clears_pending_r6: assert property (@(posedge clk) disable iff (rst)
        (vs_rise_i && !wr_good_i) |=> !wf_o);

endmodule

// File: rtl/framed_reg_port.sv
module framed_reg_port
    import frp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_sdi,
    output logic              spi_sdo,
    output logic              spi_sdo_en,
    input  logic              vsync,
    input  logic [ADDR_W-1:0] rd_cnt_i,
    input  logic [ADDR_W-1:0] wr_cnt_i,
    input  logic [PRE_W-1:0]  hd_cnt_i,
    output logic [ADDR_W-1:0] rd_start_o,
    output logic              rd_dir_o,
    output logic [ADDR_W-1:0] wr_start_o,
    output logic [PRE_W-1:0]  hd_precount_o
);

    localparam int N_SYNC = 4;
    localparam int I_CS   = 0;
    localparam int I_SCK  = 1;
    localparam int I_SDI  = 2;
    localparam int I_VS   = 3;

    logic [N_SYNC-1:0] lvl;
    logic [N_SYNC-1:0] rise;
    logic              wr_good;
    logic              wr_bad;
    logic              rd_req;
    logic              st_req;
    logic              pe;
    logic              wf;
    cfg_t              wr_data;
    cfg_t              live;
    counts_t           counts;

    frp_sync #(
        .WIDTH   (N_SYNC),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (N_SYNC'(1) << I_CS)
    ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .d_i    ({vsync, spi_sdi, spi_sck, spi_cs_n}),
        .lvl_o  (lvl),
        .rise_o (rise)
    );

    frp_rx u_rx (
        .clk        (clk),
        .rst        (rst),
        .cs_n_i     (lvl[I_CS]),
        .sck_rise_i (rise[I_SCK]),
        .sdi_i      (lvl[I_SDI]),
        .wr_good_o  (wr_good),
        .wr_bad_o   (wr_bad),
        .wr_data_o  (wr_data),
        .rd_req_o   (rd_req),
        .st_req_o   (st_req)
    );

    assign counts = '{rd: rd_cnt_i, wr: wr_cnt_i, hd: hd_cnt_i};

    frp_tx u_tx (
        .clk        (clk),
        .rst        (rst),
        .cs_n_i     (lvl[I_CS]),
        .sck_rise_i (rise[I_SCK]),
        .rd_req_i   (rd_req),
        .st_req_i   (st_req),
        .counts_i   (counts),
        .pe_i       (pe),
        .wf_i       (wf),
        .sdo_o      (spi_sdo),
        .sdo_en_o   (spi_sdo_en)
    );

    frp_commit u_commit (
        .clk       (clk),
        .rst       (rst),
        .wr_good_i (wr_good),
        .wr_bad_i  (wr_bad),
        .wr_data_i (wr_data),
        .vs_rise_i (rise[I_VS]),
        .live_o    (live),
        .pe_o      (pe),
        .wf_o      (wf)
    );

    assign rd_start_o    = live.rd_start;
    assign rd_dir_o      = live.dir;
    assign wr_start_o    = live.wr_start;
    assign hd_precount_o = live.precount;

    // R1: nothing driven on the data pin in the cycle after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!spi_sdo_en && live == '0));

endmodule

// File: tb/tb_framed_reg_port.sv
module tb_framed_reg_port;

    localparam int HALF = 8;
    localparam logic [6:0] GOOD_CODE = 7'b1110010;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       sck = 1'b0;
    logic       sdi = 1'b0;
    logic       vsync = 1'b0;
    logic [9:0] rd_cnt = '0;
    logic [9:0] wr_cnt = '0;
    logic [7:0] hd_cnt = '0;
    logic       sdo;
    logic       sdo_en;
    logic [9:0] rd_start;
    logic       rd_dir;
    logic [9:0] wr_start;
    logic [7:0] hd_pre;

    int  n_checks = 0;
    int  n_errors = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    framed_reg_port dut (
        .clk           (clk),
        .rst           (rst),
        .spi_cs_n      (cs_n),
        .spi_sck       (sck),
        .spi_sdi       (sdi),
        .spi_sdo       (sdo),
        .spi_sdo_en    (sdo_en),
        .vsync         (vsync),
        .rd_cnt_i      (rd_cnt),
        .wr_cnt_i      (wr_cnt),
        .hd_cnt_i      (hd_cnt),
        .rd_start_o    (rd_start),
        .rd_dir_o      (rd_dir),
        .wr_start_o    (wr_start),
        .hd_precount_o (hd_pre)
    );

    // vector: [31] sync after, [30] bad parity, [29] bad stop, [28] dir,
    //         [27:18] rd start, [17:8] wr start, [7:0] pre-count
    localparam logic [31:0] VECS [6] = '{
        {1'b1, 1'b0, 1'b0, 1'b0, 10'h155, 10'h2AA, 8'h10},
        {1'b0, 1'b0, 1'b0, 1'b1, 10'h3FF, 10'h001, 8'hFF},
        {1'b0, 1'b0, 1'b1, 1'b0, 10'h0AA, 10'h0BB, 8'hCC},
        {1'b1, 1'b1, 1'b0, 1'b0, 10'h123, 10'h321, 8'h44},
        {1'b0, 1'b0, 1'b0, 1'b0, 10'h200, 10'h3FE, 8'h81},
        {1'b1, 1'b0, 1'b0, 1'b1, 10'h0AB, 10'h100, 8'h5A}
    };

    // bench model state
    logic [28:0] m_live = '0;
    logic [28:0] m_shadow = '0;
    logic        m_pe = 1'b0;
    logic        m_wf = 1'b0;

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer_byte(input logic [7:0] b, output logic [7:0] got,
                             output logic en_all, output logic en_any);
        en_all = 1'b1;
        en_any = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            sdi = b[i];
            wait_clks(HALF);
            got[i] = sdo;
            en_all = en_all & sdo_en;
            en_any = en_any | sdo_en;
            sck = 1'b1;
            wait_clks(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic frame_begin();
        cs_n = 1'b0;
        wait_clks(HALF);
    endtask

    task automatic frame_end();
        wait_clks(HALF);
        cs_n = 1'b1;
        wait_clks(HALF);
    endtask

    task automatic pulse_vsync();
        vsync = 1'b1;
        wait_clks(HALF);
        vsync = 1'b0;
        wait_clks(HALF);
    endtask

    task automatic send_write(input logic [7:0] cmd, input logic [28:0] f,
                              input logic bad_stop, input logic bad_par, input int nbytes);
        logic [7:0] b [7];
        logic [6:0] code;
        logic       p;
        logic [7:0] got;
        logic       ea;
        logic       en;
        b[0] = cmd;
        b[1] = {5'b0, f[28], f[27:26]};
        b[2] = f[25:18];
        b[3] = {6'b0, f[17:16]};
        b[4] = f[15:8];
        b[5] = f[7:0];
        code = bad_stop ? 7'b1110011 : GOOD_CODE;
        p = ^{b[1], b[2], b[3], b[4], b[5], code};
        if (bad_par) p = ~p;
        b[6] = {code, p};
        frame_begin();
        for (int k = 0; k < nbytes; k++) xfer_byte(b[k], got, ea, en);
        frame_end();
    endtask

    task automatic check_status(input string req, input logic pe, input logic wf);
        logic [7:0] got;
        logic       ea;
        logic       en;
        frame_begin();
        xfer_byte(8'hF8, got, ea, en);
        check("R10", "enable during status command byte", 64'(en), 64'd0);
        xfer_byte(8'h00, got, ea, en);
        frame_end();
        check("R9", "enable across status byte", 64'(ea), 64'd1);
        check(req, "status byte", 64'(got), 64'({pe, wf, 6'b0}));
    endtask

    task automatic check_live(input string req, input logic [28:0] exp);
        check(req, "live outputs", 64'({rd_dir, rd_start, wr_start, hd_pre}), 64'(exp));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0]  got;
        logic [39:0] word;
        logic        ea;
        logic        en;
        logic        all_en;
        logic        any_en;

        wait_clks(6);
        rst = 1'b0;
        wait_clks(6);

        // R1: reset state
        check_live("R1", '0);
        check("R1", "sdo_en after reset", 64'(sdo_en), 64'd0);
        check_status("R1", 1'b0, 1'b0);

        // table walk: R3 R4 R5 R6 R7
        for (int k = 0; k < 6; k++) begin
            logic [31:0] v;
            v = VECS[k];
            send_write(8'h04, v[28:0], v[29], v[30], 7);
            if (v[29] || v[30]) begin
                m_pe = 1'b1;
            end else begin
                m_shadow = v[28:0];
                m_wf = 1'b1;
                m_pe = 1'b0;
            end
            check("R5", "live before sync", 64'({rd_dir, rd_start, wr_start, hd_pre}), 64'(m_live));
            check_status((v[29] || v[30]) ? "R4" : "R5", m_pe, m_wf);
            if (v[31]) begin
                pulse_vsync();
                if (m_wf) m_live = m_shadow;
                m_wf = 1'b0;
                check_live((k == 5) ? "R7" : "R3", m_live);
                check_status("R6", m_pe, m_wf);
            end
        end

        // R8: counter read and R10 enable window
        rd_cnt = 10'h2C5;
        wr_cnt = 10'h13A;
        hd_cnt = 8'h9E;
        frame_begin();
        xfer_byte(8'h08, got, ea, en);
        check("R10", "enable during read command byte", 64'(en), 64'd0);
        all_en = 1'b1;
        for (int k = 4; k >= 0; k--) begin
            xfer_byte(8'h00, got, ea, en);
            word[k*8 +: 8] = got;
            all_en = all_en & ea;
        end
        rd_cnt = 10'h000;
        check("R10", "enable across 40 return bits", 64'(all_en), 64'd1);
        xfer_byte(8'h00, got, ea, any_en);
        check("R10", "enable after last return bit", 64'(any_en), 64'd0);
        frame_end();
        check("R8", "counter word", 64'(word), 64'({6'b0, 10'h2C5, 6'b0, 10'h13A, 8'h9E}));
        check("R10", "enable while deselected", 64'(sdo_en), 64'd0);

        // R2: ignored command bytes carrying a valid payload
        send_write(8'h0C, 29'h1ABCDEF, 1'b0, 1'b0, 7);
        send_write(8'h54, 29'h1ABCDEF, 1'b0, 1'b0, 7);
        send_write(8'h05, 29'h1ABCDEF, 1'b0, 1'b0, 7);
        check_status("R2", m_pe, m_wf);
        pulse_vsync();
        check_live("R2", m_live);

        // R2: status group with both enables returns nothing
        frame_begin();
        xfer_byte(8'hFC, got, ea, en);
        xfer_byte(8'h00, got, ea, any_en);
        frame_end();
        check("R2", "enable after prohibited status command", 64'(any_en), 64'd0);

        // R11: frame cut before stop byte, then a sync edge
        send_write(8'h04, 29'h0F0F0F0, 1'b0, 1'b0, 5);
        check_status("R11", m_pe, m_wf);
        pulse_vsync();
        check_live("R11", m_live);

        // R4: bad parity with nothing pending keeps live values after sync
        send_write(8'h04, 29'h0777777, 1'b0, 1'b1, 7);
        m_pe = 1'b1;
        check_status("R4", m_pe, m_wf);
        pulse_vsync();
        check_live("R4", m_live);

        // R1: reset with a pending write
        send_write(8'h04, 29'h1234567, 1'b0, 1'b0, 7);
        check_status("R5", 1'b0, 1'b1);
        @(negedge clk);
        rst = 1'b1;
        wait_clks(4);
        rst = 1'b0;
        wait_clks(4);
        check_live("R1", '0);
        check_status("R1", 1'b0, 1'b0);
        pulse_vsync();
        check_live("R1", '0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule